// File: doc/BRIEF.md
# Prefixed 8-bit Opcode Decoder

This block turns one opcode byte of an 8-bit accumulator machine into a compact set of control fields. It reports an operation class, a sub-operation code, destination and source register selects, a register-pair select, a branch condition with an enable, a restart address, a bit index, the full instruction length in bytes, and a flag that marks a prefix byte. The top two opcode bits split the space into four groups. Most operand selects come straight from fixed bit fields.

A fetch unit drives one byte per cycle on `opcode_i`. When the previous byte was the page prefix 0xCB, the fetch unit raises `pfx_i`, and the current byte is then decoded from the second opcode page. All outputs are registered. The decode of a byte presented before a rising edge appears just after that edge and holds until the next one. Fetching immediates and executing instructions happen elsewhere.

Top module: `op_decoder`

## Requirements
- R1: While `rst_n` is low, and right after it, `cls_o` is 0 (no-op), `len_o` is 1, and every other output is 0.
- R2: The byte on `opcode_i`/`pfx_i` at a rising edge shows up on the outputs just after that edge. The outputs then stay stable until the next edge.
- R3: Class codes on `cls_o`: 0 nop, 1 accumulator misc, 2 load pair immediate, 3 store A indirect, 4 load A indirect, 5 store SP to immediate address, 6 pair increment, 7 pair decrement, 8 add pair to HL, 9 register increment, 10 register decrement, 11 load register immediate, 12 relative jump, 13 stop, 14 move, 15 halt, 16 ALU with register, 17 ALU with immediate, 18 return, 19 return from interrupt, 20 absolute jump, 21 jump to HL, 22 call, 23 restart, 24 pop, 25 push, 26 store A high/absolute, 27 load A high/absolute, 28 add to SP, 29 HL from SP offset, 30 SP from HL, 31 interrupts off, 32 interrupts on, 33 prefixed shift, 34 prefixed bit test, 35 prefixed bit reset, 36 prefixed bit set, 37 prefix byte. `sub_o` is 0 for every class except 1, 16, 17, 26, 27 and 33.
- R4: Group 00 (bits 7:6 = 00) decodes as follows. 0x00 is nop. 0x08 is class 5. 0x10 is stop. 0x18 is an unconditional relative jump. Bits 2:0 = 000 with bit 5 set is a conditional relative jump. Low nibble 0001/1001 gives class 2/8, 0010/1010 gives 3/4, and 0011/1011 gives 6/7. Bits 2:0 = 100/101/110 give class 9/10/11. Bits 2:0 = 111 give class 1, with `sub_o` = bits 5:3 (0 rotate-left-circular, 1 rotate-right-circular, 2 rotate-left, 3 rotate-right, 4 decimal adjust, 5 complement, 6 set carry, 7 flip carry).
- R5: `dst_o` always carries opcode bits 5:3 and `src_o` always carries bits 2:0. Register code 0..7 means B, C, D, E, H, L, memory at HL, A. Group 01 is class 14 (move bits 2:0 into bits 5:3).
- R6: 0x76 decodes as halt (class 15), not as a move.
- R7: Group 10 is class 16. `sub_o` = bits 5:3, where 0..7 is add, add-with-carry, subtract, subtract-with-borrow, and, xor, or, compare.
- R8: `pair_o` carries bits 5:4. For classes 2, 6, 7 and 8 it means BC, DE, HL, SP. For push and pop it means BC, DE, HL, AF. For classes 3 and 4 it means BC, DE, HL-then-increment, HL-then-decrement.
- R9: `cond_o` carries bits 4:3, where 0..3 is not-zero, zero, not-carry, carry. `cond_en_o` is 1 for 0x20/0x28/0x30/0x38, 0xC0/C8/D0/D8, 0xC2/CA/D2/DA and 0xC4/CC/D4/DC. It is 0 for every other byte, including 0x18, 0xC9, 0xC3 and 0xCD.
- R10: For the restart class (group 11, bits 2:0 = 111), `rst_addr_o` = bits 5:3 times 8. For every other class it is 0.
- R11: Without `pfx_i`, 0xCB gives class 37 with `prefix_o` = 1 and length 2. With `pfx_i` = 1, bits 7:6 = 00/01/10/11 give class 33/34/35/36. For class 33, `sub_o` = bits 5:3 (0..7: rlc, rrc, rl, rr, sla, sra, swap, srl). For classes 34..36, `bit_o` = bits 5:3. The register is in `src_o`, `len_o` = 2 and `prefix_o` = 0. `bit_o` is 0 for all other classes.
- R12: `len_o` is 3 for classes 2, 5, 20 and 22, and for 0xEA/0xFA. It is 2 for classes 11, 12, 17, 28, 29 and 37, for 0xE0/0xF0, and for every prefixed byte. It is 1 otherwise.
- R13: The remaining group 11 bytes decode as follows. 0xC9 is return, 0xD9 is class 19, 0xE9 is class 21, 0xF9 is class 30, 0xF3 is class 31 and 0xFB is class 32. Bytes with bit 3 clear and bits 2:0 = 001 are pop, and with bits 2:0 = 101 they are push. 0xE2/0xE0/0xEA are class 26 and 0xF2/0xF0/0xFA are class 27, with `sub_o` 0/1/2 (C-indexed high page, immediate high page, absolute). 0xE8 is class 28 and 0xF8 is class 29. Bits 2:0 = 110 give class 17 with `sub_o` = bits 5:3 in the R7 order. 0xC3 is jump and 0xCD is call.
- R14: 0xD3, 0xDB, 0xDD, 0xE3, 0xE4, 0xEB, 0xEC, 0xED, 0xF4, 0xFC and 0xFD decode as a 1-byte nop with `cond_en_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_i | input | 1 | Current byte is the second byte of a prefixed instruction |
| opcode_i | input | 8 | Opcode byte to decode |
| cls_o | output | CLS_W | Operation class |
| sub_o | output | 3 | Sub-operation (ALU op, shift kind, misc op, transfer mode) |
| dst_o | output | 3 | Register select from bits 5:3 |
| src_o | output | 3 | Register select from bits 2:0 |
| pair_o | output | 2 | Register-pair select from bits 5:4 |
| cond_o | output | 2 | Condition from bits 4:3 |
| cond_en_o | output | 1 | Instruction is conditional |
| bit_o | output | 3 | Bit index for prefixed bit operations |
| rst_addr_o | output | 8 | Restart target address |
| len_o | output | 2 | Instruction length in bytes |
| prefix_o | output | 1 | A prefix byte was decoded |

## Verification
Every output is one register stage from the input byte, so the only state is the previous decode. A wrong decode, such as a misplaced priority between a specific byte and its group pattern, shows up on `cls_o` or `len_o` on the first edge after the byte is presented. A stuck or stale register shows up on the next byte, when an output fails to change. The bench walks every class and all lengths. It uses the two prefix paths and the unassigned bytes as the corner cases that separate a correct decoder from one that falls through to the wrong pattern.

// File: rtl/op_decoder.sv
module op_decoder #(
  parameter int CLS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pfx_i,
  input  logic [7:0]       opcode_i,
  output logic [CLS_W-1:0] cls_o,
  output logic [2:0]       sub_o,
  output logic [2:0]       dst_o,
  output logic [2:0]       src_o,
  output logic [1:0]       pair_o,
  output logic [1:0]       cond_o,
  output logic             cond_en_o,
  output logic [2:0]       bit_o,
  output logic [7:0]       rst_addr_o,
  output logic [1:0]       len_o,
  output logic             prefix_o
);

  localparam logic [CLS_W-1:0] K_NOP = 0, K_MISC = 1, K_LD16I = 2, K_STIND = 3,
    K_LDIND = 4, K_STSP = 5, K_INC16 = 6, K_DEC16 = 7, K_ADDHL = 8, K_INC8 = 9,
    K_DEC8 = 10, K_LD8I = 11, K_JR = 12, K_STOP = 13, K_MOV = 14, K_HALT = 15,
    K_ALUR = 16, K_ALUI = 17, K_RET = 18, K_RETI = 19, K_JP = 20, K_JPHL = 21,
    K_CALL = 22, K_RST = 23, K_POP = 24, K_PUSH = 25, K_IOST = 26, K_IOLD = 27,
    K_ADDSP = 28, K_HLSP = 29, K_SPHL = 30, K_DI = 31, K_EI = 32, K_CBSH = 33,
    K_CBBIT = 34, K_CBRES = 35, K_CBSET = 36, K_PFX = 37;

  logic [CLS_W-1:0] c_cls;
  logic [2:0] c_sub, c_bit;
  logic [1:0] c_len;
  logic       c_cen;
  logic [7:0] c_rst;
  wire  [1:0] blk = opcode_i[7:6];
  wire  [2:0] f53 = opcode_i[5:3];

  always_comb begin
    c_cls = K_NOP; c_sub = '0; c_bit = '0; c_len = 2'd1; c_cen = 1'b0; c_rst = '0;
    if (pfx_i) begin
      c_len = 2'd2;
      case (blk)
        2'b00: begin c_cls = K_CBSH; c_sub = f53; end
        2'b01: begin c_cls = K_CBBIT; c_bit = f53; end
        2'b10: begin c_cls = K_CBRES; c_bit = f53; end
        default: begin c_cls = K_CBSET; c_bit = f53; end
      endcase
    end else begin
      case (blk)
        2'b00: begin
          if (opcode_i == 8'h00) c_cls = K_NOP;
          else if (opcode_i == 8'h08) begin c_cls = K_STSP; c_len = 2'd3; end
          else if (opcode_i == 8'h10) c_cls = K_STOP;
          else if (opcode_i == 8'h18) begin c_cls = K_JR; c_len = 2'd2; end
          else begin
            case (opcode_i[2:0])
              3'b000: begin c_cls = K_JR; c_len = 2'd2; c_cen = 1'b1; end
              3'b001: if (opcode_i[3]) c_cls = K_ADDHL;
                      else begin c_cls = K_LD16I; c_len = 2'd3; end
              3'b010: c_cls = opcode_i[3] ? K_LDIND : K_STIND;
              3'b011: c_cls = opcode_i[3] ? K_DEC16 : K_INC16;
              3'b100: c_cls = K_INC8;
              3'b101: c_cls = K_DEC8;
              3'b110: begin c_cls = K_LD8I; c_len = 2'd2; end
              default: begin c_cls = K_MISC; c_sub = f53; end
            endcase
          end
        end
        2'b01: c_cls = (opcode_i == 8'h76) ? K_HALT : K_MOV;
        2'b10: begin c_cls = K_ALUR; c_sub = f53; end
        default: begin
          case (opcode_i[2:0])
            3'b000: if (!opcode_i[5]) begin c_cls = K_RET; c_cen = 1'b1; end
                    else begin
                      c_len = 2'd2;
                      case (opcode_i[4:3])
                        2'b00: begin c_cls = K_IOST; c_sub = 3'd1; end
                        2'b01: c_cls = K_ADDSP;
                        2'b10: begin c_cls = K_IOLD; c_sub = 3'd1; end
                        default: c_cls = K_HLSP;
                      endcase
                    end
            3'b001: if (!opcode_i[3]) c_cls = K_POP;
                    else case (opcode_i[5:4])
                      2'b00: c_cls = K_RET;
                      2'b01: c_cls = K_RETI;
                      2'b10: c_cls = K_JPHL;
                      default: c_cls = K_SPHL;
                    endcase
            3'b010: if (!opcode_i[5]) begin c_cls = K_JP; c_len = 2'd3; c_cen = 1'b1; end
                    else case (opcode_i[4:3])
                      2'b00: c_cls = K_IOST;
                      2'b01: begin c_cls = K_IOST; c_sub = 3'd2; c_len = 2'd3; end
                      2'b10: c_cls = K_IOLD;
                      default: begin c_cls = K_IOLD; c_sub = 3'd2; c_len = 2'd3; end
                    endcase
            3'b011: case (f53)
                      3'b000: begin c_cls = K_JP; c_len = 2'd3; end
                      3'b001: begin c_cls = K_PFX; c_len = 2'd2; end
                      3'b110: c_cls = K_DI;
                      3'b111: c_cls = K_EI;
                      default: c_cls = K_NOP;
                    endcase
            3'b100: if (!opcode_i[5]) begin c_cls = K_CALL; c_len = 2'd3; c_cen = 1'b1; end
            3'b101: if (!opcode_i[3]) c_cls = K_PUSH;
                    else if (opcode_i == 8'hCD) begin c_cls = K_CALL; c_len = 2'd3; end
            3'b110: begin c_cls = K_ALUI; c_sub = f53; c_len = 2'd2; end
            default: begin c_cls = K_RST; c_rst = {f53, 3'b000}; end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_o <= K_NOP; sub_o <= '0; dst_o <= '0; src_o <= '0; pair_o <= '0;
      cond_o <= '0; cond_en_o <= 1'b0; bit_o <= '0; rst_addr_o <= '0;
      len_o <= 2'd1; prefix_o <= 1'b0;
    end else begin
      cls_o <= c_cls; sub_o <= c_sub; dst_o <= f53; src_o <= opcode_i[2:0];
      pair_o <= opcode_i[5:4]; cond_o <= opcode_i[4:3]; cond_en_o <= c_cen;
      bit_o <= c_bit; rst_addr_o <= c_rst; len_o <= c_len;
      prefix_o <= (c_cls == K_PFX);
    end
  end

  assert_mov_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_i && opcode_i[7:6] == 2'b01 && opcode_i != 8'h76) |=>
    (cls_o == K_MOV && dst_o == $past(opcode_i[5:3]) && src_o == $past(opcode_i[2:0])));
  assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_i && opcode_i == 8'h76) |=> (cls_o == K_HALT && len_o == 2'd1));
  assert_alu_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_i && opcode_i[7:6] == 2'b10) |=> (cls_o == K_ALUR && sub_o == $past(opcode_i[5:3])));
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_i && opcode_i[7:6] == 2'b11 && opcode_i[2:0] == 3'b111) |=>
    (cls_o == K_RST && rst_addr_o == {$past(opcode_i[5:3]), 3'b000}));
  assert_page2_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_i |=> (len_o == 2'd2 && !prefix_o && cls_o >= K_CBSH && cls_o <= K_CBSET));
  assert_unassigned_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_i && opcode_i == 8'hD3) |=> (cls_o == K_NOP && len_o == 2'd1 && !cond_en_o));

endmodule

// File: tb/sim_op_decoder.sv
module sim_op_decoder;
  logic clk = 1'b0, rst_n = 1'b0, pfx = 1'b0;
  logic [7:0] op = 8'h76;
  logic [5:0] cls; logic [2:0] sub, dst, src, bitx; logic [1:0] pair, cond, len;
  logic cen, pfxo; logic [7:0] rsta;
  int total = 0, bad = 0; bit done = 0;

  always #5 clk = ~clk;

  op_decoder u0 (.clk(clk), .rst_n(rst_n), .pfx_i(pfx), .opcode_i(op), .cls_o(cls),
    .sub_o(sub), .dst_o(dst), .src_o(src), .pair_o(pair), .cond_o(cond),
    .cond_en_o(cen), .bit_o(bitx), .rst_addr_o(rsta), .len_o(len), .prefix_o(pfxo));

  // {req, pfx, opcode, class, sub, len, cond_en}
  localparam int NV = 51;
  localparam logic [24:0] VEC [NV] = '{
    {4'd4, 1'b0, 8'h00, 6'd0,  3'd0, 2'd1, 1'b0},  // R4 block 00
    {4'd4, 1'b0, 8'h01, 6'd2,  3'd0, 2'd3, 1'b0},
    {4'd4, 1'b0, 8'h02, 6'd3,  3'd0, 2'd1, 1'b0},
    {4'd4, 1'b0, 8'h3A, 6'd4,  3'd0, 2'd1, 1'b0},
    {4'd4, 1'b0, 8'h08, 6'd5,  3'd0, 2'd3, 1'b0},
    {4'd4, 1'b0, 8'h33, 6'd6,  3'd0, 2'd1, 1'b0},
    {4'd4, 1'b0, 8'h2B, 6'd7,  3'd0, 2'd1, 1'b0},
    {4'd4, 1'b0, 8'h09, 6'd8,  3'd0, 2'd1, 1'b0},
    {4'd4, 1'b0, 8'h3C, 6'd9,  3'd0, 2'd1, 1'b0},
    {4'd4, 1'b0, 8'h05, 6'd10, 3'd0, 2'd1, 1'b0},
    {4'd4, 1'b0, 8'h3E, 6'd11, 3'd0, 2'd2, 1'b0},
    {4'd4, 1'b0, 8'h2F, 6'd1,  3'd5, 2'd1, 1'b0},
    {4'd4, 1'b0, 8'h07, 6'd1,  3'd0, 2'd1, 1'b0},
    {4'd4, 1'b0, 8'h3F, 6'd1,  3'd7, 2'd1, 1'b0},
    {4'd9, 1'b0, 8'h18, 6'd12, 3'd0, 2'd2, 1'b0},  // R9 conditional or not
    {4'd9, 1'b0, 8'h38, 6'd12, 3'd0, 2'd2, 1'b1},
    {4'd4, 1'b0, 8'h10, 6'd13, 3'd0, 2'd1, 1'b0},
    {4'd5, 1'b0, 8'h50, 6'd14, 3'd0, 2'd1, 1'b0},  // R5 move
    {4'd6, 1'b0, 8'h76, 6'd15, 3'd0, 2'd1, 1'b0},  // R6 halt
    {4'd7, 1'b0, 8'h9E, 6'd16, 3'd3, 2'd1, 1'b0},  // R7 ALU register
    {4'd7, 1'b0, 8'hBF, 6'd16, 3'd7, 2'd1, 1'b0},
    {4'd13, 1'b0, 8'hD6, 6'd17, 3'd2, 2'd2, 1'b0}, // R13 block 11
    {4'd9, 1'b0, 8'hC9, 6'd18, 3'd0, 2'd1, 1'b0},
    {4'd9, 1'b0, 8'hD8, 6'd18, 3'd0, 2'd1, 1'b1},
    {4'd13, 1'b0, 8'hD9, 6'd19, 3'd0, 2'd1, 1'b0},
    {4'd9, 1'b0, 8'hC3, 6'd20, 3'd0, 2'd3, 1'b0},
    {4'd9, 1'b0, 8'hCA, 6'd20, 3'd0, 2'd3, 1'b1},
    {4'd13, 1'b0, 8'hE9, 6'd21, 3'd0, 2'd1, 1'b0},
    {4'd9, 1'b0, 8'hCD, 6'd22, 3'd0, 2'd3, 1'b0},
    {4'd9, 1'b0, 8'hDC, 6'd22, 3'd0, 2'd3, 1'b1},
    {4'd10, 1'b0, 8'hEF, 6'd23, 3'd0, 2'd1, 1'b0}, // R10 restart
    {4'd13, 1'b0, 8'hF1, 6'd24, 3'd0, 2'd1, 1'b0},
    {4'd13, 1'b0, 8'hC5, 6'd25, 3'd0, 2'd1, 1'b0},
    {4'd13, 1'b0, 8'hE2, 6'd26, 3'd0, 2'd1, 1'b0},
    {4'd13, 1'b0, 8'hE0, 6'd26, 3'd1, 2'd2, 1'b0},
    {4'd13, 1'b0, 8'hEA, 6'd26, 3'd2, 2'd3, 1'b0},
    {4'd13, 1'b0, 8'hF0, 6'd27, 3'd1, 2'd2, 1'b0},
    {4'd13, 1'b0, 8'hFA, 6'd27, 3'd2, 2'd3, 1'b0},
    {4'd13, 1'b0, 8'hE8, 6'd28, 3'd0, 2'd2, 1'b0},
    {4'd13, 1'b0, 8'hF8, 6'd29, 3'd0, 2'd2, 1'b0},
    {4'd13, 1'b0, 8'hF9, 6'd30, 3'd0, 2'd1, 1'b0},
    {4'd13, 1'b0, 8'hF3, 6'd31, 3'd0, 2'd1, 1'b0},
    {4'd13, 1'b0, 8'hFB, 6'd32, 3'd0, 2'd1, 1'b0},
    {4'd11, 1'b0, 8'hCB, 6'd37, 3'd0, 2'd2, 1'b0}, // R11 prefix paths
    {4'd11, 1'b1, 8'h37, 6'd33, 3'd6, 2'd2, 1'b0},
    {4'd11, 1'b1, 8'h7C, 6'd34, 3'd0, 2'd2, 1'b0},
    {4'd11, 1'b1, 8'h86, 6'd35, 3'd0, 2'd2, 1'b0},
    {4'd11, 1'b1, 8'hFF, 6'd36, 3'd0, 2'd2, 1'b0},
    {4'd14, 1'b0, 8'hE4, 6'd0,  3'd0, 2'd1, 1'b0}, // R14 unassigned
    {4'd14, 1'b0, 8'hDD, 6'd0,  3'd0, 2'd1, 1'b0},
    {4'd14, 1'b0, 8'hFC, 6'd0,  3'd0, 2'd1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic p, input logic [7:0] b);
    @(negedge clk);
    pfx = p; op = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset class", cls, 0);
    chk("R1", "reset len", len, 1);
    chk("R1", "reset prefix", pfxo, 0);
    chk("R1", "reset restart", rsta, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string rq;
      apply(VEC[i][20], VEC[i][19:12]);
      rq = $sformatf("R%0d", VEC[i][24:21]);
      chk(rq, $sformatf("class op=%h", VEC[i][19:12]), cls, VEC[i][11:6]);
      chk(rq, $sformatf("sub op=%h", VEC[i][19:12]), sub, VEC[i][5:3]);
      chk("R12", $sformatf("len op=%h", VEC[i][19:12]), len, VEC[i][2:1]);
      chk("R9", $sformatf("cond_en op=%h", VEC[i][19:12]), cen, VEC[i][0]);
    end

    apply(1'b0, 8'h4A);
    chk("R5", "dst C", dst, 1);
    chk("R5", "src D", src, 2);
    apply(1'b0, 8'h35);
    chk("R5", "dst memHL", dst, 6);
    chk("R3", "dec8 class", cls, 10);
    apply(1'b0, 8'hE5);
    chk("R8", "push pair HL", pair, 2);
    chk("R8", "push class", cls, 25);
    apply(1'b0, 8'h3A);
    chk("R8", "indirect pair HL-", pair, 3);
    apply(1'b0, 8'h30);
    chk("R9", "cond not-carry", cond, 2);
    chk("R9", "cond_en", cen, 1);
    apply(1'b0, 8'hFF);
    chk("R10", "restart 7", rsta, 8'h38);
    apply(1'b0, 8'hC7);
    chk("R10", "restart 0", rsta, 8'h00);
    apply(1'b0, 8'hD7);
    chk("R10", "restart 2", rsta, 8'h10);
    apply(1'b0, 8'h00);
    chk("R10", "no restart", rsta, 8'h00);
    apply(1'b0, 8'hCB);
    chk("R11", "prefix flag", pfxo, 1);
    apply(1'b1, 8'h5E);
    chk("R11", "bit index", bitx, 3);
    chk("R11", "bit reg", src, 6);
    chk("R11", "prefix flag second", pfxo, 0);
    apply(1'b0, 8'h5E);
    chk("R11", "bit index outside page", bitx, 0);
    chk("R5", "move class", cls, 14);
    apply(1'b0, 8'hD3);
    chk("R14", "unassigned class", cls, 0);
    chk("R14", "unassigned len", len, 1);

    apply(1'b0, 8'h76);
    @(negedge clk); pfx = 1'b0; op = 8'h00; #1;
    chk("R2", "held before edge", cls, 15);
    @(posedge clk); #1;
    chk("R2", "updated after edge", cls, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule